// File: doc/BRIEF.md
# Indirect Register Select Window

This block sits on the CSR path of a processor core and gives software an index-based window onto a set of indirectly addressed registers. Each of three privilege levels (machine, supervisor, virtual supervisor) owns a select register and six alias CSR numbers. The current select value of a level, together with the alias used, picks one entry of a small table of implemented registers. That entry names a backing register slot or a constant-zero location. Reads return the chosen register. Writes update it on the next clock edge.

While the hart runs virtualized, the supervisor-level select and alias numbers are served by the virtual-supervisor copies. Select values with the top bit set form a custom range, separate from the standard range. On the 32-bit datapath, a 64-bit indirect register is split into two halves: the low half is reached through aliases 1 to 3 and the high half through aliases 4 to 6. Permission checks by privilege and state-enable are made by a neighbouring block. This block only raises an illegal-instruction request when no table entry matches the access.

Top module: `ind_sel_window`

## Requirements
- R1: The machine select register decodes at CSR 0x350. Its aliases decode at 0x351, 0x352, 0x353, 0x355, 0x356 and 0x357, which are alias indices 1 to 6 in that order, and `csr_hit` is high for each of them.
- R2: A CSR number whose low byte is 0x54 is not decoded. `csr_hit` is 0, `csr_rdata` is 0 and `csr_illegal` is 0, and a write to it changes no register.
- R3: The supervisor set decodes at 0x150 to 0x157 and the virtual-supervisor set at 0x250 to 0x257, with the same gap. Each level has its own select register.
- R4: When `virt_mode` is 1, accesses to 0x150 to 0x157 read and write the virtual-supervisor select register and state. Accesses to 0x25x are unchanged.
- R5: Every select register is WARL. A write keeps bits 11:0 and bit 31 and clears all other bits. Reading it returns the stored value.
- R6: Select value 0x010 at machine level is one 64-bit register: alias 1 (0x351) reaches its low half and alias 4 (0x355) its high half, as independent slots.
- R7: Select value 0x010 with alias 2 (0x352) reads as zero. Writes to it are dropped, and `csr_illegal` stays 0.
- R8: An alias access whose level, select value and alias index match no table entry drives `csr_illegal` to 1 and `csr_rdata` to 0, and does not write. Select-register accesses never raise `csr_illegal`.
- R9: Writes take effect at the clock edge that ends the strobe cycle. During the strobe cycle, `csr_rdata` shows the old value, combinationally from the current select value.
- R10: The custom select value 0x80000003 with alias 3 reaches its own slot at machine level. The standard value 0x00000003 with the same alias is unimplemented.
- R11: After reset, all select registers and backing slots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_en | input | 1 | A CSR access is presented this cycle |
| csr_we | input | 1 | The access writes `csr_wdata` |
| csr_addr | input | 12 | CSR number |
| csr_wdata | input | 32 | Write data |
| virt_mode | input | 1 | Hart is executing virtualized |
| csr_rdata | output | 32 | Read data for the access |
| csr_hit | output | 1 | The CSR number belongs to this block |
| csr_illegal | output | 1 | Alias access to an unimplemented combination |

## Verification
The assertions check on every cycle that the 0x54 gap never decodes, that select accesses never flag illegal, that WARL masking holds after each select write, that virtualized supervisor writes land only in the virtual copy, and that backing slots change only when written. Only the bench scenarios show the full mapping of select and alias values to stored data: the low/high halves being independent, read-zero and miss entries dropping writes, the custom range being separate from the standard one, and the old value being returned during the write cycle.

// File: rtl/ind_pkg.sv
package ind_pkg;

    localparam int XLEN      = 32;
    localparam int SEL_BITS  = 12;
    localparam int NUM_ENT   = 8;
    localparam int NUM_SLOTS = 7;
    localparam int NUM_LVL   = 3;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    localparam logic [XLEN-1:0] SEL_KEEP =
        {1'b1, {(XLEN-SEL_BITS-1){1'b0}}, {SEL_BITS{1'b1}}};

    typedef enum logic [1:0] {
        LVL_M  = 2'd0,
        LVL_S  = 2'd1,
        LVL_VS = 2'd2
    } lvl_e;

    typedef struct packed {
        logic       valid;
        lvl_e       lvl;
        logic       is_sel;
        logic [2:0] alias_idx;
    } dec_t;

    typedef struct packed {
        lvl_e              lvl;
        logic [XLEN-1:0]   sel;
        logic [2:0]        alias_idx;
        logic              rdzero;
        logic [SLOT_W-1:0] slot;
    } ent_t;

    function automatic logic [XLEN-1:0] warl_sel(input logic [XLEN-1:0] v);
        return v & SEL_KEEP;
    endfunction

    // Implemented indirect registers: level, select, alias, zero flag, slot.
    function automatic ent_t tbl_entry(input int i);
        ent_t e;
        e = '{lvl: LVL_M, sel: '0, alias_idx: 3'd0, rdzero: 1'b0, slot: '0};
        case (i)
            0: e = '{LVL_M,  32'h0000_0010, 3'd1, 1'b0, 3'd0};
            1: e = '{LVL_M,  32'h0000_0010, 3'd4, 1'b0, 3'd1};
            2: e = '{LVL_M,  32'h0000_0010, 3'd2, 1'b1, 3'd0};
            3: e = '{LVL_S,  32'h0000_0020, 3'd1, 1'b0, 3'd2};
            4: e = '{LVL_S,  32'h0000_0020, 3'd4, 1'b0, 3'd3};
            5: e = '{LVL_VS, 32'h0000_0020, 3'd1, 1'b0, 3'd4};
            6: e = '{LVL_VS, 32'h0000_0020, 3'd4, 1'b0, 3'd5};
            7: e = '{LVL_M,  32'h8000_0003, 3'd3, 1'b0, 3'd6};
            default: e.alias_idx = 3'd0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/ind_csr_decode.sv
module ind_csr_decode
    import ind_pkg::*;
(
    input  logic [11:0] addr,
    input  logic        virt,
    output dec_t        dec
);
    logic base_ok;

    always_comb begin
        dec     = '0;
        dec.lvl = LVL_M;
        base_ok = 1'b1;
        case (addr[11:8])
            4'h3:    dec.lvl = LVL_M;
            4'h1:    dec.lvl = virt ? LVL_VS : LVL_S;
            4'h2:    dec.lvl = LVL_VS;
            default: base_ok = 1'b0;
        endcase
        dec.valid     = base_ok && (addr[7:4] == 4'h5) && !addr[3]
                        && (addr[2:0] != 3'd4);
        dec.is_sel    = (addr[2:0] == 3'd0);
        dec.alias_idx = addr[2] ? (addr[2:0] - 3'd1) : addr[2:0];
    end
endmodule

// File: rtl/ind_sel_regs.sv
module ind_sel_regs
    import ind_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  lvl_e                           wr_lvl,
    input  logic [XLEN-1:0]                wdata,
    output logic [NUM_LVL-1:0][XLEN-1:0]   sel_q
);
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst)
                sel_q[l] <= '0;
            else if (wr_en && (wr_lvl == lvl_e'(l)))
                sel_q[l] <= warl_sel(wdata);
        end

        a_r5_warl_keep: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_lvl == lvl_e'(l)) |=>
                (sel_q[l][XLEN-2:SEL_BITS] == '0) &&
                (sel_q[l][SEL_BITS-1:0] == $past(wdata[SEL_BITS-1:0])) &&
                (sel_q[l][XLEN-1] == $past(wdata[XLEN-1])));
    end
endmodule

// File: rtl/ind_lookup.sv
module ind_lookup
    import ind_pkg::*;
(
    input  lvl_e              lvl,
    input  logic [2:0]        alias_idx,
    input  logic [XLEN-1:0]   sel,
    output logic              hit,
    output logic              rdzero,
    output logic [SLOT_W-1:0] slot
);
    logic [NUM_ENT-1:0] match;

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        localparam ent_t E = tbl_entry(i);
        assign match[i] = (lvl == E.lvl) && (sel == E.sel)
                          && (alias_idx == E.alias_idx);
    end

    always_comb begin
        hit    = 1'b0;
        rdzero = 1'b0;
        slot   = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit    = 1'b1;
                rdzero = tbl_entry(i).rdzero;
                slot   = tbl_entry(i).slot;
            end
        end
    end
endmodule

// File: rtl/ind_backing.sv
module ind_backing
    import ind_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [SLOT_W-1:0]               slot,
    input  logic [XLEN-1:0]                 wdata,
    output logic [XLEN-1:0]                 rdata
);
    logic [NUM_SLOTS-1:0][XLEN-1:0] mem_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[s] <= '0;
            else if (we && slot == SLOT_W'(s))
                mem_q[s] <= wdata;
        end
    end

    assign rdata = (int'(slot) < NUM_SLOTS) ? mem_q[slot] : '0;

    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem_q));

    a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> mem_q[$past(slot)] == $past(wdata));
endmodule

// File: rtl/ind_sel_window.sv
module ind_sel_window
    import ind_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_en,
    input  logic        csr_we,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    input  logic        virt_mode,
    output logic [31:0] csr_rdata,
    output logic        csr_hit,
    output logic        csr_illegal
);
    dec_t                         dec;
    logic [NUM_LVL-1:0][XLEN-1:0] sel_q;
    logic [XLEN-1:0]              sel_cur;
    logic                         lk_hit, lk_zero;
    logic [SLOT_W-1:0]            lk_slot;
    logic [XLEN-1:0]              slot_rd;
    logic                         alias_acc, sel_we, slot_we;

    ind_csr_decode u_dec (
        .addr (csr_addr),
        .virt (virt_mode),
        .dec  (dec)
    );

    assign sel_we = csr_en && csr_we && dec.valid && dec.is_sel;

    ind_sel_regs u_sel (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (sel_we),
        .wr_lvl (dec.lvl),
        .wdata  (csr_wdata),
        .sel_q  (sel_q)
    );

    assign sel_cur = sel_q[dec.lvl];

    ind_lookup u_lk (
        .lvl       (dec.lvl),
        .alias_idx (dec.alias_idx),
        .sel       (sel_cur),
        .hit       (lk_hit),
        .rdzero    (lk_zero),
        .slot      (lk_slot)
    );

    assign alias_acc = csr_en && dec.valid && !dec.is_sel;
    assign slot_we   = alias_acc && csr_we && lk_hit && !lk_zero;

    ind_backing u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (slot_we),
        .slot  (lk_slot),
        .wdata (csr_wdata),
        .rdata (slot_rd)
    );

    assign csr_hit     = csr_en && dec.valid;
    assign csr_illegal = alias_acc && !lk_hit;

    always_comb begin
        if (!csr_hit)
            csr_rdata = '0;
        else if (dec.is_sel)
            csr_rdata = sel_cur;
        else if (!lk_hit || lk_zero)
            csr_rdata = '0;
        else
            csr_rdata = slot_rd;
    end

    a_r2_gap_ignored: assert property (@(posedge clk) disable iff (rst)
        (csr_en && csr_addr[7:0] == 8'h54) |-> (!csr_hit && !csr_illegal));

    a_r8_select_never_illegal: assert property (@(posedge clk) disable iff (rst)
        (csr_en && csr_addr[7:0] == 8'h50) |-> !csr_illegal);

    a_r4_virt_write_to_vs: assert property (@(posedge clk) disable iff (rst)
        (csr_en && csr_we && virt_mode && csr_addr == 12'h150) |=>
            (sel_q[LVL_VS] == warl_sel($past(csr_wdata))) && $stable(sel_q[LVL_S]));

    a_r8_illegal_no_rdata: assert property (@(posedge clk) disable iff (rst)
        csr_illegal |-> (csr_rdata == '0 && csr_hit));
endmodule

// File: tb/test_ind_sel_window.sv
module test_ind_sel_window;

    logic        clk = 1'b0;
    logic        rst;
    logic        csr_en, csr_we, virt_mode;
    logic [11:0] csr_addr;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic        csr_hit, csr_illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [31:0] rd;
        logic        ill;
        logic        hit;
        string       tag;
    } item_t;

    item_t exp_q[$];
    event  smp_ev;

    always #4 clk = ~clk;

    ind_sel_window i_ind_sel_window (
        .clk         (clk),
        .rst         (rst),
        .csr_en      (csr_en),
        .csr_we      (csr_we),
        .csr_addr    (csr_addr),
        .csr_wdata   (csr_wdata),
        .virt_mode   (virt_mode),
        .csr_rdata   (csr_rdata),
        .csr_hit     (csr_hit),
        .csr_illegal (csr_illegal)
    );

    // Monitor: pops expected items and compares against outputs.
    initial begin
        forever begin
            @(smp_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                n_tests++;
                if (csr_rdata !== it.rd || csr_illegal !== it.ill || csr_hit !== it.hit) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h ill=%b hit=%b expected rdata=%h ill=%b hit=%b",
                             it.tag, csr_rdata, csr_illegal, csr_hit, it.rd, it.ill, it.hit);
                end
            end
        end
    end

    // Driver: presents one access, queues its expected result, then lets the edge pass.
    task automatic acc(input logic [11:0] a, input logic we, input logic [31:0] wd,
                       input logic v, input logic [31:0] erd, input logic eill,
                       input logic ehit, input string tag);
        item_t it;
        @(negedge clk);
        csr_en    = 1'b1;
        csr_we    = we;
        csr_addr  = a;
        csr_wdata = wd;
        virt_mode = v;
        #2;
        it.rd  = erd;
        it.ill = eill;
        it.hit = ehit;
        it.tag = tag;
        exp_q.push_back(it);
        -> smp_ev;
        @(posedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_fail++;
                n_tests++;
                $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<=20000", cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; csr_en = 1'b0; csr_we = 1'b0; csr_addr = '0;
        csr_wdata = '0; virt_mode = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        acc(12'h350, 0, 0, 0, 32'h0, 0, 1, "R11 machine select after reset");
        acc(12'h150, 0, 0, 0, 32'h0, 0, 1, "R11 supervisor select after reset");
        acc(12'h250, 0, 0, 0, 32'h0, 0, 1, "R11 virtual select after reset");
        // R5 WARL
        acc(12'h350, 1, 32'hFFFF_FFFF, 0, 32'h0, 0, 1, "R5 select write returns old");
        acc(12'h350, 0, 0, 0, 32'h8000_0FFF, 0, 1, "R5 select keeps low 12 and top bit");
        acc(12'h350, 1, 32'h0000_0010, 0, 32'h8000_0FFF, 0, 1, "R5 select rewrite");
        // R6 / R9 / R1 split halves
        acc(12'h351, 1, 32'h1111_2222, 0, 32'h0, 0, 1, "R9 low half old value during write");
        acc(12'h355, 1, 32'hAAAA_BBBB, 0, 32'h0, 0, 1, "R9 high half old value during write");
        acc(12'h351, 0, 0, 0, 32'h1111_2222, 0, 1, "R6 low half via alias 1 (R1)");
        acc(12'h355, 0, 0, 0, 32'hAAAA_BBBB, 0, 1, "R6 high half via alias 4 (R1)");
        // R7 read-zero
        acc(12'h352, 1, 32'h5, 0, 32'h0, 0, 1, "R7 read-zero write");
        acc(12'h352, 0, 0, 0, 32'h0, 0, 1, "R7 read-zero stays zero");
        // R8 unimplemented combination
        acc(12'h353, 1, 32'h1234_5678, 0, 32'h0, 1, 1, "R8 write to miss flags illegal");
        acc(12'h353, 0, 0, 0, 32'h0, 1, 1, "R8 read of miss flags illegal");
        acc(12'h351, 0, 0, 0, 32'h1111_2222, 0, 1, "R8 miss write left state alone");
        acc(12'h356, 0, 0, 0, 32'h0, 1, 1, "R1 alias 5 decodes, no entry");
        // R2 gap
        acc(12'h354, 1, 32'hDEAD, 0, 32'h0, 0, 0, "R2 gap write not decoded");
        acc(12'h354, 0, 0, 0, 32'h0, 0, 0, "R2 gap read not decoded");
        acc(12'h355, 0, 0, 0, 32'hAAAA_BBBB, 0, 1, "R2 gap write touched nothing");
        // R3 supervisor set
        acc(12'h150, 1, 32'h20, 0, 32'h0, 0, 1, "R3 supervisor select write");
        acc(12'h151, 1, 32'h5, 0, 32'h0, 0, 1, "R3 supervisor alias write");
        acc(12'h151, 0, 0, 0, 32'h5, 0, 1, "R3 supervisor alias read");
        acc(12'h250, 0, 0, 0, 32'h0, 0, 1, "R3 virtual select independent");
        acc(12'h251, 0, 0, 0, 32'h0, 1, 1, "R3 virtual alias with select 0 is miss");
        // R4 virtualized routing
        acc(12'h150, 0, 0, 1, 32'h0, 0, 1, "R4 virt select reads virtual copy");
        acc(12'h150, 1, 32'h20, 1, 32'h0, 0, 1, "R4 virt select write");
        acc(12'h151, 1, 32'h77, 1, 32'h0, 0, 1, "R4 virt alias write");
        acc(12'h251, 0, 0, 0, 32'h77, 0, 1, "R4 data landed in virtual copy");
        acc(12'h151, 0, 0, 0, 32'h5, 0, 1, "R4 supervisor copy untouched");
        acc(12'h150, 0, 0, 0, 32'h20, 0, 1, "R4 supervisor select untouched");
        // R10 custom range
        acc(12'h350, 1, 32'h8000_0003, 0, 32'h10, 0, 1, "R10 custom select write");
        acc(12'h353, 1, 32'hC0DE, 0, 32'h0, 0, 1, "R10 custom alias write");
        acc(12'h353, 0, 0, 0, 32'hC0DE, 0, 1, "R10 custom alias read");
        acc(12'h350, 1, 32'h3, 0, 32'h8000_0003, 0, 1, "R10 standard select write");
        acc(12'h353, 0, 0, 0, 32'h0, 1, 1, "R10 standard value unimplemented");

        @(negedge clk);
        csr_en = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule